// File: doc/BRIEF.md
# Radix Page-Tree Walker

This block turns an effective address into a real address by walking a multi-level radix page tree held in memory. A request supplies the root table base, the root's index width, the starting page-size exponent and the effective address. The walker then reads one 64-bit entry per level through a read port with a request handshake and a response strobe, and it follows directory entries until it reaches a leaf.

Each level's index width comes from the entry that points to it, so table sizes can vary from level to level. The page-size exponent shrinks by that width after every read. The exponent that remains when the leaf is reached selects how many low effective-address bits pass through into the real address.

A walk ends with a one-cycle completion pulse. The pulse carries either the translation (real address, page-size exponent, leaf entry and leaf entry address) or a fault cause. Permission checking and nested translation of table addresses belong to other blocks.

Top module: `radix_walker`

## Requirements
- R1: After reset `req_ready` is 1, while `done` and `rd_valid` are 0. `req_ready` is 1 exactly when the walker is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R2: If a level's index width is below 5, the walk ends with a bad-configuration fault (`fault_cause` = 2'b01) without issuing a read for that level.
- R3: If a level's index width exceeds the current page-size exponent, the walk ends with a bad-configuration fault (2'b01) without issuing that level's read.
- R4: The read address of a level is base + 8 × ((EA >> (psize − width)) & (2^width − 1)).
- R5: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_addr` stays unchanged on the next cycle.
- R6: A returned entry with bit 63 clear ends the walk with a no-entry fault (`fault_cause` = 2'b10).
- R7: An entry with bit 63 set and bit 62 clear is a directory. Its bits [4:0] give the next index width, and its bits [55:8] (low 8 bits zero) give the next base. After every read, the page-size exponent drops by the width of the level just read.
- R8: An entry with bits 63 and 62 set is a leaf. `res_raddr` = (entry bits [55:12], low psize bits cleared) | (EA low psize bits). `res_psize` is the reduced exponent, and `res_entry` and `res_entry_addr` are the leaf and its address.
- R9: A walk that has made MAX_LEVELS reads without reaching a leaf ends with a bad-configuration fault (2'b01) and makes no further read.
- R10: Every walk ends with `done` high for exactly one cycle. `fault` is 1 with a nonzero cause on faults, and 0 with cause 2'b00 on success.
- R11: `req_valid` while the walker is busy is ignored: it starts no read and produces no extra completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_base | input | 64 | Root table base address |
| req_nls | input | 5 | Root index width |
| req_psize | input | 6 | Starting page-size exponent |
| req_ea | input | 64 | Effective address to translate |
| rd_valid | output | 1 | Entry read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 64 | Entry address |
| rd_resp_valid | input | 1 | Read data strobe |
| rd_resp_data | input | 64 | Entry returned by memory |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 01 bad configuration, 10 no entry |
| res_raddr | output | 64 | Real address |
| res_psize | output | 6 | Final page-size exponent |
| res_entry | output | 64 | Leaf entry |
| res_entry_addr | output | 64 | Address of the last entry read |

## Verification
The assertions assume three things about the inputs. The root base is 8-byte aligned. Memory returns exactly one response per accepted read. No response arrives while the walker is not waiting for one. The bench's memory model keeps to this: it starts a countdown only on an observed handshake, raises the response strobe for a single cycle when the countdown expires, and uses only aligned bases. It varies the response latency and the back-pressure pattern so that the hold-while-stalled behaviour is exercised.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
    localparam int unsigned ENTRY_W  = 64;
    localparam int unsigned NLS_W    = 5;
    localparam int unsigned PS_W     = 6;
    localparam int unsigned MIN_NLS  = 5;
    localparam int unsigned VALID_BIT = 63;
    localparam int unsigned LEAF_BIT  = 62;
    localparam logic [ENTRY_W-1:0] NEXT_BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
    localparam logic [ENTRY_W-1:0] RPN_MASK       = 64'h00FF_FFFF_FFFF_F000;

    localparam logic [1:0] CAUSE_NONE   = 2'b00;
    localparam logic [1:0] CAUSE_BADCFG = 2'b01;
    localparam logic [1:0] CAUSE_NOPTE  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/rw_index_gen.sv
module rw_index_gen
    import rwalk_pkg::*;
(
    input  logic [ENTRY_W-1:0] base,
    input  logic [ENTRY_W-1:0] ea,
    input  logic [NLS_W-1:0]   nls,
    input  logic [PS_W-1:0]    psize,
    output logic [ENTRY_W-1:0] entry_addr
);
    logic [PS_W-1:0]    shamt;
    logic [ENTRY_W-1:0] idx_mask;
    logic [ENTRY_W-1:0] idx;

    always_comb begin
        shamt      = psize - PS_W'(nls);
        idx_mask   = (64'd1 << nls) - 64'd1;
        idx        = (ea >> shamt) & idx_mask;
        entry_addr = base + (idx << 3);
    end
endmodule

// File: rtl/rw_leaf_compose.sv
module rw_leaf_compose
    import rwalk_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [ENTRY_W-1:0] ea,
    input  logic [PS_W-1:0]    psize,
    output logic [ENTRY_W-1:0] raddr
);
    logic [ENTRY_W-1:0] page_mask;

    always_comb begin
        page_mask = (64'd1 << psize) - 64'd1;
        raddr     = (entry & RPN_MASK & ~page_mask) | (ea & page_mask);
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import rwalk_pkg::*;
#(
    parameter int unsigned MAX_LEVELS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ENTRY_W-1:0] req_base,
    input  logic [NLS_W-1:0]   req_nls,
    input  logic [PS_W-1:0]    req_psize,
    input  logic [ENTRY_W-1:0] req_ea,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic [ENTRY_W-1:0] rd_addr,
    input  logic               rd_resp_valid,
    input  logic [ENTRY_W-1:0] rd_resp_data,
    output logic               done,
    output logic               fault,
    output logic [1:0]         fault_cause,
    output logic [ENTRY_W-1:0] res_raddr,
    output logic [PS_W-1:0]    res_psize,
    output logic [ENTRY_W-1:0] res_entry,
    output logic [ENTRY_W-1:0] res_entry_addr
);
    localparam int unsigned LVL_W = $clog2(MAX_LEVELS + 1);

    typedef struct packed {
        walk_state_e        st;
        logic [ENTRY_W-1:0] base;
        logic [NLS_W-1:0]   nls;
        logic [PS_W-1:0]    psize;
        logic [ENTRY_W-1:0] ea;
        logic [LVL_W-1:0]   lvl;
        logic               done;
        logic               fault;
        logic [1:0]         cause;
        logic [ENTRY_W-1:0] raddr;
        logic [PS_W-1:0]    res_ps;
        logic [ENTRY_W-1:0] entry;
        logic [ENTRY_W-1:0] eaddr;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [ENTRY_W-1:0] entry_addr;
    logic [ENTRY_W-1:0] leaf_raddr;
    logic [PS_W-1:0]    ps_after;
    logic               cfg_bad;

    rw_index_gen u_index (
        .base       (q.base),
        .ea         (q.ea),
        .nls        (q.nls),
        .psize      (q.psize),
        .entry_addr (entry_addr)
    );

    rw_leaf_compose u_leaf (
        .entry (rd_resp_data),
        .ea    (q.ea),
        .psize (ps_after),
        .raddr (leaf_raddr)
    );

    always_comb begin
        ps_after = q.psize - PS_W'(q.nls);
        cfg_bad  = (q.nls < NLS_W'(MIN_NLS))
                || (PS_W'(q.nls) > q.psize)
                || (q.lvl == LVL_W'(MAX_LEVELS));
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_ISSUE;
                    d.base  = req_base;
                    d.nls   = req_nls;
                    d.psize = req_psize;
                    d.ea    = req_ea;
                    d.lvl   = '0;
                end
            end
            ST_ISSUE: begin
                if (cfg_bad) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.fault = 1'b1;
                    d.cause = CAUSE_BADCFG;
                end else if (rd_ready) begin
                    d.st    = ST_WAIT;
                    d.eaddr = entry_addr;
                end
            end
            ST_WAIT: begin
                if (rd_resp_valid) begin
                    if (!rd_resp_data[VALID_BIT]) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b1;
                        d.cause = CAUSE_NOPTE;
                    end else if (rd_resp_data[LEAF_BIT]) begin
                        d.st     = ST_IDLE;
                        d.done   = 1'b1;
                        d.fault  = 1'b0;
                        d.cause  = CAUSE_NONE;
                        d.raddr  = leaf_raddr;
                        d.res_ps = ps_after;
                        d.entry  = rd_resp_data;
                    end else begin
                        d.st    = ST_ISSUE;
                        d.psize = ps_after;
                        d.nls   = rd_resp_data[NLS_W-1:0];
                        d.base  = rd_resp_data & NEXT_BASE_MASK;
                        d.lvl   = q.lvl + LVL_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready      = (q.st == ST_IDLE);
    assign rd_valid       = (q.st == ST_ISSUE) && !cfg_bad;
    assign rd_addr        = entry_addr;
    assign done           = q.done;
    assign fault          = q.fault;
    assign fault_cause    = q.cause;
    assign res_raddr      = q.raddr;
    assign res_psize      = q.res_ps;
    assign res_entry      = q.entry;
    assign res_entry_addr = q.eaddr;

    // R11: an accepted request makes the walker busy on the next cycle
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R5: a stalled read request holds
    a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    // R4: entry addresses stay 8-byte aligned (aligned root base assumed)
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_addr[2:0] == 3'b000);

    // R9: no read once the level budget is spent
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> q.lvl < LVL_W'(MAX_LEVELS));

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: cause agrees with the fault flag
    a_r10_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (fault_cause != CAUSE_NONE)) && (fault_cause != 2'b11));

    // R8: low page bits of the result come straight from the EA
    a_r8_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> ((res_raddr ^ q.ea) & ((64'd1 << res_psize) - 64'd1)) == 64'd0);
endmodule

// File: tb/test_radix_walker.sv
module test_radix_walker;
    import rwalk_pkg::*;

    localparam int MAXL = 4;
    localparam logic [63:0] DIRF  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LEAFF = 64'hC000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_base = '0;
    logic [4:0]  req_nls = '0;
    logic [5:0]  req_psize = '0;
    logic [63:0] req_ea = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [63:0] rd_addr;
    logic        rd_resp_valid = 1'b0;
    logic [63:0] rd_resp_data = '0;
    logic        done;
    logic        fault;
    logic [1:0]  fault_cause;
    logic [63:0] res_raddr;
    logic [5:0]  res_psize;
    logic [63:0] res_entry;
    logic [63:0] res_entry_addr;

    always #4 clk = ~clk;

    radix_walker #(.MAX_LEVELS(MAXL)) i_radix_walker (
        .clk, .rst_n, .req_valid, .req_ready, .req_base, .req_nls, .req_psize,
        .req_ea, .rd_valid, .rd_ready, .rd_addr, .rd_resp_valid, .rd_resp_data,
        .done, .fault, .fault_cause, .res_raddr, .res_psize, .res_entry,
        .res_entry_addr
    );

    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];
    int checks = 0, fails = 0;
    int cyc = 0, cd = 0, lat = 1;
    bit busy = 0, stall = 0, prev_stalled = 0, prev_done = 0, got_done = 0;
    logic [63:0] pend_addr = '0, prev_addr = '0;
    logic        g_fault;
    logic [1:0]  g_cause;
    logic [63:0] g_raddr, g_entry, g_eaddr;
    logic [5:0]  g_ps;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] ent_addr(input logic [63:0] b, input int n,
                                             input int p, input logic [63:0] e);
        return b + (((e >> (p - n)) & ((64'd1 << n) - 64'd1)) << 3);
    endfunction

    function automatic logic [63:0] rd_mem(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // behavioural reference walk; pushes expected read addresses
    task automatic model(input logic [63:0] b, input int n, input int p,
                         input logic [63:0] e, output logic [1:0] cause,
                         output logic [63:0] raddr, output int rps,
                         output logic [63:0] entry, output logic [63:0] eaddr);
        logic [63:0] base = b, a, ent, m;
        int nls = n, ps = p;
        cause = 2'b00; raddr = '0; rps = 0; entry = '0; eaddr = '0;
        for (int lvl = 0; ; lvl++) begin
            if (nls < 5 || nls > ps || lvl == MAXL) begin cause = 2'b01; return; end
            a = ent_addr(base, nls, ps, e);
            exp_q.push_back(a);
            ent = rd_mem(a);
            ps = ps - nls;
            if (!ent[63]) begin cause = 2'b10; return; end
            if (ent[62]) begin
                m = (64'd1 << ps) - 64'd1;
                raddr = (ent & 64'h00FF_FFFF_FFFF_F000 & ~m) | (e & m);
                rps = ps; entry = ent; eaddr = a;
                return;
            end
            nls = int'(ent[4:0]);
            base = ent & 64'h00FF_FFFF_FFFF_FF00;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (done) begin
            chk(busy, "R11", "completion without a walk", 64'(done), 64'(busy));
            chk(!prev_done, "R10", "done wider than one cycle", 64'(prev_done), 0);
            g_fault = fault; g_cause = fault_cause; g_raddr = res_raddr;
            g_ps = res_psize; g_entry = res_entry; g_eaddr = res_entry_addr;
            got_done = 1; busy = 0;
        end
        prev_done = done;
        if (req_ready == busy)
            chk(0, "R1", "req_ready vs idle", 64'(req_ready), 64'(!busy));
        if (prev_stalled) begin
            chk(rd_valid && rd_addr == prev_addr, "R5", "stalled read changed",
                rd_addr, prev_addr);
        end
        rd_resp_valid = 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin rd_resp_valid = 1'b1; rd_resp_data = rd_mem(pend_addr); end
        end
        rd_ready = stall ? (cyc % 3 == 0) : 1'b1;
        prev_stalled = rd_valid && !rd_ready;
        prev_addr = rd_addr;
        if (rd_valid && rd_ready) begin
            if (exp_q.size() == 0) chk(0, "R2", "unexpected read", rd_addr, 0);
            else begin
                logic [63:0] ea_exp;
                ea_exp = exp_q.pop_front();
                chk(rd_addr == ea_exp, "R4", "entry address", rd_addr, ea_exp);
            end
            pend_addr = rd_addr;
            cd = lat;
        end
    endtask

    task automatic run(input logic [63:0] b, input int n, input int p,
                       input logic [63:0] e, input string req, input bit poke);
        logic [1:0] ec; logic [63:0] er, ee, ea; int eps;
        model(b, n, p, e, ec, er, eps, ee, ea);
        chk(req_ready, "R1", "ready before request", 64'(req_ready), 1);
        req_base = b; req_nls = 5'(n); req_psize = 6'(p); req_ea = e;
        req_valid = 1'b1; busy = 1; got_done = 0;
        tick();
        req_valid = 1'b0;
        if (poke) begin
            req_base = 64'h0F00_0000; req_nls = 5'd13; req_psize = 6'd52;
            req_valid = 1'b1;
            tick(); tick();
            req_valid = 1'b0;
        end
        for (int t = 0; t < 2000 && !got_done; t++) tick();
        if (!got_done) chk(0, req, "watchdog expired", 0, 1);
        chk(g_cause == ec, req, "fault cause", 64'(g_cause), 64'(ec));
        chk(g_fault == (ec != 2'b00), "R10", "fault flag", 64'(g_fault), 64'(ec != 0));
        if (ec == 2'b00) begin
            chk(g_raddr == er, "R8", "real address", g_raddr, er);
            chk(g_ps == 6'(eps), "R7", "final page size", 64'(g_ps), 64'(eps));
            chk(g_entry == ee, "R8", "leaf entry", g_entry, ee);
            chk(g_eaddr == ea, "R8", "leaf entry address", g_eaddr, ea);
        end
        chk(exp_q.size() == 0, req, "reads missing", 64'(exp_q.size()), 0);
        exp_q.delete();
        for (int t = 0; t < 4; t++) tick();
        if (poke) chk(!got_done || busy == 0, "R11", "busy request ignored", 64'(busy), 0);
    endtask

    logic [63:0] ea_a, ea_b, ea_c;

    initial begin
        ea_a = 64'h0000_1234_5678_9ABC;
        ea_b = 64'h0000_7654_3210_FEDC;
        ea_c = 64'h0000_0ACE_1357_2468;
        // three-level walk ending in a 2^21 page
        mem[ent_addr(64'h100000, 13, 52, ea_a)] = DIRF | 64'h110000 | 9;
        mem[ent_addr(64'h110000, 9, 39, ea_a)]  = DIRF | 64'h120000 | 9;
        mem[ent_addr(64'h120000, 9, 30, ea_a)]  = LEAFF | 64'h00AB_CDE0_0000;
        // four-level walk ending in a 2^12 page
        mem[ent_addr(64'h200000, 13, 52, ea_b)] = DIRF | 64'h210000 | 9;
        mem[ent_addr(64'h210000, 9, 39, ea_b)]  = DIRF | 64'h220000 | 9;
        mem[ent_addr(64'h220000, 9, 30, ea_b)]  = DIRF | 64'h230000 | 9;
        mem[ent_addr(64'h230000, 9, 21, ea_b)]  = LEAFF | 64'h0000_0F00_D000;
        // missing second level
        mem[ent_addr(64'h300000, 13, 52, ea_c)] = DIRF | 64'h310000 | 9;
        // directory naming a too-small next level
        mem[ent_addr(64'h400000, 13, 52, ea_c)] = DIRF | 64'h410000 | 3;
        // endless chain of directories
        mem[ent_addr(64'h500000, 5, 52, ea_c)] = DIRF | 64'h510000 | 5;
        mem[ent_addr(64'h510000, 5, 47, ea_c)] = DIRF | 64'h520000 | 5;
        mem[ent_addr(64'h520000, 5, 42, ea_c)] = DIRF | 64'h530000 | 5;
        mem[ent_addr(64'h530000, 5, 37, ea_c)] = DIRF | 64'h540000 | 5;
        // leaf straight from the root
        mem[ent_addr(64'h600000, 13, 52, ea_c)] = LEAFF | 64'h0012_3400_0000;

        repeat (3) @(negedge clk);
        chk(req_ready, "R1", "reset ready", 64'(req_ready), 1);
        chk(!done, "R1", "reset done", 64'(done), 0);
        chk(!rd_valid, "R1", "reset read", 64'(rd_valid), 0);
        rst_n = 1'b1;

        run(64'h100000, 13, 52, ea_a, "R8", 0);
        run(64'h200000, 13, 52, ea_b, "R7", 0);
        run(64'h300000, 13, 52, ea_c, "R6", 0);
        run(64'h300000, 4, 52, ea_c, "R2", 0);
        run(64'h400000, 13, 52, ea_c, "R2", 0);
        run(64'h300000, 13, 10, ea_c, "R3", 0);
        run(64'h500000, 5, 52, ea_c, "R9", 0);
        run(64'h600000, 13, 52, ea_c, "R8", 0);
        run(64'h100000, 13, 52, ea_a, "R11", 1);
        stall = 1; lat = 3;
        run(64'h200000, 13, 52, ea_b, "R5", 0);
        run(64'h100000, 13, 52, ea_a, "R5", 0);
        stall = 0; lat = 2;
        run(64'h300000, 13, 52, ea_c, "R6", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule